// File: doc/BRIEF.md
# Last-Round Fault Key-Byte Filter

This block narrows down one byte of a block cipher's last-round key using pairs of ciphertexts produced from the same plaintext: one computed correctly and one computed with a fault injected just before the final byte substitution. Such a fault disturbs a single ciphertext byte. The block finds that byte and then tests all 256 values of the key byte at that position. For each guess it undoes the final substitution on both ciphertext bytes with the inverse S-box and XORs the two results. This gives the fault value that the guess implies. The guess survives only when that value fits the fault model chosen for the pair.

One guess is tested per clock, so a valid pair takes 256 cycles. The survivors of each pair come out as a 256-bit mask. That mask is ANDed into a running candidate mask, which keeps only the key-byte values that are consistent with every pair seen since the last clear. A running population count of that mask is reported at the same time. A pair in which no byte differs, or in which more than one byte differs, is rejected at once and leaves the running state as it was. The user clears the running mask before moving on to a new byte position.

Top module: `dfa_keybyte_filter`

## Requirements
- R1: After reset, cand_mask is all ones, cand_count is 256, and done and busy are low.
- R2: When exactly one byte differs between ct_good and ct_bad, the pair is accepted: pair_ok is high at done and byte_pos gives that byte's index. Byte i occupies bits 8i+7 down to 8i.
- R3: When zero bytes or two or more bytes differ, done rises in the cycle after the start edge with pair_ok low and pair_mask all zero. cand_mask and cand_count keep their previous values.
- R4: For a valid pair, busy is high during the sweep and done is high for exactly one cycle, 256 clock edges after the edge that sampled start.
- R5: Bit k of pair_mask is 1 exactly when the implied fault f(k) = InvSbox(g XOR k) XOR InvSbox(b XOR k) is accepted by the model, where g and b are the differing bytes of ct_good and ct_bad.
- R6: Model code 0 accepts f(k) only when it equals fixed_fault.
- R7: Model code 1 accepts f(k) only when it has exactly one bit set.
- R8: Model code 2 accepts f(k) when it equals any of the SET_N bytes in allowed_set, where entry i is bits 8i+7 down to 8i.
- R9: Model code 3 accepts every guess.
- R10: At done after a valid pair, cand_mask equals its value before the pair ANDed with pair_mask.
- R11: At done, cand_count equals the number of ones in cand_mask.
- R12: Asserting clear sets cand_mask to all ones and cand_count to 256 on the next edge. It also abandons a sweep in progress, and no done follows.
- R13: A start pulse that arrives while busy is high is ignored. The running sweep finishes with its own byte position and mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear | input | 1 | Reset the running candidate mask to all ones |
| start | input | 1 | Sample a ciphertext pair and model settings when idle |
| ct_good | input | 128 | Correct ciphertext |
| ct_bad | input | 128 | Faulty ciphertext |
| model | input | 2 | Fault model: 0 fixed, 1 single bit, 2 set, 3 any |
| fixed_fault | input | 8 | Fault value for model 0 |
| allowed_set | input | 32 | SET_N allowed fault bytes for model 2 |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse marking a finished pair |
| pair_ok | output | 1 | Last pair had exactly one differing byte |
| byte_pos | output | 4 | Index of the differing byte |
| pair_mask | output | 256 | Survivors of the last pair |
| cand_mask | output | 256 | Running intersection of survivors |
| cand_count | output | 9 | Ones in cand_mask once done |

## Verification
The assertions rely on clear being the only event that can set candidate bits again. They also rely on start being acted on only in the idle state, so that a pair's inputs are captured once and never reread during the sweep. The stimulus holds clear low at every point except where it is being exercised on purpose. Every valid pair is built by encrypting a known state under a known key with a bench model of the last round, and then disturbing exactly one byte before substitution. Invalid pairs are built on purpose with zero or two differing bytes.

// File: rtl/dfa_filter_pkg.sv
// Shared types and GF(2^8) helpers for the key-byte filter.
// Assumes the AES field polynomial x^8+x^4+x^3+x+1.
package dfa_filter_pkg;

    typedef enum logic [1:0] {
        FM_FIXED  = 2'd0,
        FM_ONEBIT = 2'd1,
        FM_SET    = 2'd2,
        FM_ANY    = 2'd3
    } fmodel_e;

    // Field multiply, shift-and-add with reduction.
    function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] acc;
        logic [7:0] aa;
        acc = 8'h00;
        aa  = a;
        for (int i = 0; i < 8; i++) begin
            if (b[i]) acc = acc ^ aa;
            aa = aa[7] ? ((aa << 1) ^ 8'h1b) : (aa << 1);
        end
        return acc;
    endfunction

    // Field inverse as x^254; maps 0 to 0.
    function automatic logic [7:0] gf_inv(input logic [7:0] x);
        logic [7:0] p;
        logic [7:0] r;
        p = x;
        r = 8'h01;
        for (int i = 1; i < 8; i++) begin
            p = gf_mul(p, p);
            r = gf_mul(r, p);
        end
        return r;
    endfunction

    function automatic logic [7:0] rotl8(input logic [7:0] v, input int n);
        return (v << n) | (v >> (8 - n));
    endfunction

endpackage

// File: rtl/dfa_inv_sbox.sv
// Combinational inverse S-box: inverse affine map followed by field inverse.
// Assumes nothing beyond an 8-bit input; no state.
module dfa_inv_sbox
    import dfa_filter_pkg::*;
(
    input  logic [7:0] din,
    output logic [7:0] dout
);
    logic [7:0] pre;

    // Undo the affine transform, then invert in the field.
    always_comb begin
        pre  = rotl8(din, 1) ^ rotl8(din, 3) ^ rotl8(din, 6) ^ 8'h05;
        dout = gf_inv(pre);
    end
endmodule

// File: rtl/dfa_byte_locator.sv
// Compares two words byte by byte and reports the differing byte when
// exactly one differs. Byte i is bits 8i+7:8i. Purely combinational.
module dfa_byte_locator #(
    parameter int NBYTES = 16,
    localparam int PW    = $clog2(NBYTES)
) (
    input  logic [NBYTES*8-1:0] word_a,
    input  logic [NBYTES*8-1:0] word_b,
    output logic                single,
    output logic [PW-1:0]       pos
);
    logic [NBYTES-1:0] neq;

    genvar gi;
    generate
        for (gi = 0; gi < NBYTES; gi++) begin : g_cmp
            assign neq[gi] = (word_a[gi*8 +: 8] != word_b[gi*8 +: 8]);
        end
    endgenerate

    // Count differing bytes and pick the highest index that differs.
    always_comb begin
        logic [PW:0] cnt;
        cnt = '0;
        pos = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (neq[i]) begin
                cnt = cnt + 1'b1;
                pos = PW'(i);
            end
        end
        single = (cnt == 1);
    end
endmodule

// File: rtl/dfa_fault_model.sv
// Decides whether an implied fault value is allowed by the selected model.
// Assumes settings stay stable for the whole sweep (the top latches them).
module dfa_fault_model
    import dfa_filter_pkg::*;
#(
    parameter int SET_N = 4
) (
    input  fmodel_e              model,
    input  logic [7:0]           fault,
    input  logic [7:0]           fixed_val,
    input  logic [SET_N*8-1:0]   set_vals,
    output logic                 accept
);
    logic [SET_N-1:0] hit;

    genvar gi;
    generate
        for (gi = 0; gi < SET_N; gi++) begin : g_set
            assign hit[gi] = (fault == set_vals[gi*8 +: 8]);
        end
    endgenerate

    // Select the acceptance rule.
    always_comb begin
        case (model)
            FM_FIXED:  accept = (fault == fixed_val);
            FM_ONEBIT: accept = ($countones(fault) == 1);
            FM_SET:    accept = |hit;
            default:   accept = 1'b1;
        endcase
    end
endmodule

// File: rtl/dfa_keybyte_filter.sv
// Sweeps all 256 guesses of one last-round key byte for a ciphertext pair,
// one guess per clock, and intersects survivors into a running mask.
// Assumes ct inputs and model settings are valid while start is high;
// they are captured on the start edge and not read again.
module dfa_keybyte_filter
    import dfa_filter_pkg::*;
#(
    parameter int NBYTES = 16,
    parameter int SET_N  = 4,
    localparam int PW     = $clog2(NBYTES),
    localparam int NGUESS = 256,
    localparam int CW     = $clog2(NGUESS) + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 start,
    input  logic [NBYTES*8-1:0]  ct_good,
    input  logic [NBYTES*8-1:0]  ct_bad,
    input  logic [1:0]           model,
    input  logic [7:0]           fixed_fault,
    input  logic [SET_N*8-1:0]   allowed_set,
    output logic                 busy,
    output logic                 done,
    output logic                 pair_ok,
    output logic [PW-1:0]        byte_pos,
    output logic [NGUESS-1:0]    pair_mask,
    output logic [NGUESS-1:0]    cand_mask,
    output logic [CW-1:0]        cand_count
);
    typedef enum logic {ST_IDLE, ST_SWEEP} state_e;

    state_e             state;
    logic [7:0]         byte_g;
    logic [7:0]         byte_b;
    fmodel_e            model_q;
    logic [7:0]         fixed_q;
    logic [SET_N*8-1:0] set_q;
    logic [7:0]         guess;

    logic               loc_single;
    logic [PW-1:0]      loc_pos;
    logic [7:0]         inv_g;
    logic [7:0]         inv_b;
    logic [7:0]         implied;
    logic               accept;

    dfa_byte_locator #(.NBYTES(NBYTES)) u_loc (
        .word_a (ct_good),
        .word_b (ct_bad),
        .single (loc_single),
        .pos    (loc_pos)
    );

    dfa_inv_sbox u_isb_g (.din(byte_g ^ guess), .dout(inv_g));
    dfa_inv_sbox u_isb_b (.din(byte_b ^ guess), .dout(inv_b));

    // Fault value implied by the current guess.
    assign implied = inv_g ^ inv_b;

    dfa_fault_model #(.SET_N(SET_N)) u_fm (
        .model     (model_q),
        .fault     (implied),
        .fixed_val (fixed_q),
        .set_vals  (set_q),
        .accept    (accept)
    );

    assign busy = (state == ST_SWEEP);

    // Pair capture, guess sweep and running-mask update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            pair_ok    <= 1'b0;
            byte_pos   <= '0;
            byte_g     <= '0;
            byte_b     <= '0;
            model_q    <= FM_FIXED;
            fixed_q    <= '0;
            set_q      <= '0;
            guess      <= '0;
            pair_mask  <= '0;
            cand_mask  <= '1;
            cand_count <= CW'(NGUESS);
        end else if (clear) begin
            state      <= ST_IDLE;
            done       <= 1'b0;
            cand_mask  <= '1;
            cand_count <= CW'(NGUESS);
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        byte_pos  <= loc_pos;
                        pair_ok   <= loc_single;
                        pair_mask <= '0;
                        if (loc_single) begin
                            byte_g     <= ct_good[loc_pos*8 +: 8];
                            byte_b     <= ct_bad[loc_pos*8 +: 8];
                            model_q    <= fmodel_e'(model);
                            fixed_q    <= fixed_fault;
                            set_q      <= allowed_set;
                            guess      <= '0;
                            cand_count <= '0;
                            state      <= ST_SWEEP;
                        end else begin
                            done <= 1'b1;
                        end
                    end
                end
                default: begin
                    pair_mask[guess] <= accept;
                    cand_mask[guess] <= cand_mask[guess] & accept;
                    cand_count       <= cand_count + CW'(accept & cand_mask[guess]);
                    guess            <= guess + 8'd1;
                    if (guess == 8'(NGUESS - 1)) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // done never lasts more than one cycle.
    p_done_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // A sweep only ends by finishing (done) or by clear.
    p_sweep_ends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !clear) |=> (busy || done));

    // Candidates never reappear except through clear.
    p_mask_shrinks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !clear |=> ((cand_mask & ~$past(cand_mask)) == '0));

    // An invalid pair leaves the running state untouched.
    p_invalid_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pair_ok) |-> (cand_mask == $past(cand_mask) &&
                                cand_count == $past(cand_count)));

    // The incremental count agrees with the mask at done.
    p_count_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (32'(cand_count) == $countones(cand_mask)));

    // clear restores the full candidate set and idles.
    p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (cand_mask == '1 && !busy && !done));

    // The captured bytes under test really differ.
    p_bytes_differ_r2: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (byte_g != byte_b));
endmodule

// File: tb/dfa_keybyte_filter_test.sv
// Self-checking bench: a software last round builds faulted pairs under a
// known key; expected masks come from an independently built S-box.
module dfa_keybyte_filter_test;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clear = 1'b0;
    logic         start = 1'b0;
    logic [127:0] ct_good = '0;
    logic [127:0] ct_bad = '0;
    logic [1:0]   model = 2'd0;
    logic [7:0]   fixed_fault = 8'h00;
    logic [31:0]  allowed_set = '0;
    logic         busy, done, pair_ok;
    logic [3:0]   byte_pos;
    logic [255:0] pair_mask, cand_mask;
    logic [8:0]   cand_count;

    int total = 0;
    int bad = 0;

    logic [7:0]   sb [256];
    logic [7:0]   isb [256];
    logic [255:0] exp_cand;
    logic [127:0] key = 128'h0f1e2d3c4b5a69788796a5b4c3d2e1f0;
    logic [127:0] st0 = 128'h3243f6a8885a308d313198a2e0370734;

    // captured at done
    int           cyc;
    logic         s_ok;
    logic [3:0]   s_pos;
    logic [255:0] s_pm, s_cm;
    logic [8:0]   s_cnt;

    dfa_keybyte_filter uut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .start(start),
        .ct_good(ct_good), .ct_bad(ct_bad), .model(model),
        .fixed_fault(fixed_fault), .allowed_set(allowed_set),
        .busy(busy), .done(done), .pair_ok(pair_ok), .byte_pos(byte_pos),
        .pair_mask(pair_mask), .cand_mask(cand_mask), .cand_count(cand_count)
    );

    always #2 clk = ~clk;

    function automatic logic [7:0] tmul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p;
        p = '0;
        for (int i = 0; i < 8; i++) if (b[i]) p = p ^ (16'(a) << i);
        for (int i = 15; i >= 8; i--) if (p[i]) p = p ^ (16'h11b << (i - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] tinv(input logic [7:0] x);
        logic [7:0] r;
        r = 8'h00;
        for (int y = 1; y < 256; y++) if (tmul(x, 8'(y)) == 8'h01) r = 8'(y);
        return r;
    endfunction

    function automatic logic [127:0] enc(input logic [127:0] st);
        logic [127:0] o;
        for (int i = 0; i < 16; i++) o[i*8 +: 8] = sb[st[i*8 +: 8]] ^ key[i*8 +: 8];
        return o;
    endfunction

    function automatic logic [255:0] exp_mask(input logic [7:0] g, input logic [7:0] b,
                                              input logic [1:0] m, input logic [7:0] fx,
                                              input logic [31:0] st);
        logic [255:0] r;
        logic [7:0]   f;
        int           ones;
        for (int k = 0; k < 256; k++) begin
            f = isb[g ^ 8'(k)] ^ isb[b ^ 8'(k)];
            ones = 0;
            for (int j = 0; j < 8; j++) ones += int'(f[j]);
            case (m)
                2'd0: r[k] = (f == fx);
                2'd1: r[k] = (ones == 1);
                2'd2: r[k] = (f == st[7:0]) || (f == st[15:8]) || (f == st[23:16]) || (f == st[31:24]);
                default: r[k] = 1'b1;
            endcase
        end
        return r;
    endfunction

    function automatic int pop(input logic [255:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 256; i++) n += int'(v[i]);
        return n;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [255:0] act, input logic [255:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, expv);
        end
    endtask

    // Drive one pair, wait for done, snapshot outputs, confirm one-cycle done.
    task automatic run_pair(input logic [127:0] g, input logic [127:0] b, input logic [1:0] m,
                            input logic [7:0] fx, input logic [31:0] st);
        @(negedge clk);
        ct_good = g; ct_bad = b; model = m; fixed_fault = fx; allowed_set = st;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        s_ok = pair_ok; s_pos = byte_pos; s_pm = pair_mask; s_cm = cand_mask; s_cnt = cand_count;
        @(negedge clk);
        chk(!done, "R4 done one cycle", 256'(done), 256'(0));
    endtask

    // Valid pair with a fault byte e at position p; checks R2 R4 R5 R10 R11.
    task automatic valid_pair(input int p, input logic [7:0] e, input logic [1:0] m,
                              input logic [7:0] fx, input logic [31:0] st, input string tag);
        logic [127:0] g, b;
        logic [255:0] em;
        g = enc(st0);
        b = enc(st0 ^ (128'(e) << (8 * p)));
        em = exp_mask(g[p*8 +: 8], b[p*8 +: 8], m, fx, st);
        run_pair(g, b, m, fx, st);
        exp_cand = exp_cand & em;
        chk(cyc == 257, {"R4 latency ", tag}, 256'(cyc), 256'(257));
        chk(s_ok, {"R2 pair_ok ", tag}, 256'(s_ok), 256'(1));
        chk(s_pos == 4'(p), {"R2 byte_pos ", tag}, 256'(s_pos), 256'(p));
        chk(s_pm == em, {"R5 pair_mask ", tag}, s_pm, em);
        chk(s_cm == exp_cand, {"R10 cand_mask ", tag}, s_cm, exp_cand);
        chk(int'(s_cnt) == pop(exp_cand), {"R11 cand_count ", tag}, 256'(s_cnt), 256'(pop(exp_cand)));
    endtask

    task automatic do_clear();
        @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_cand = '1;
    endtask

    initial begin
        #(4 * 200000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [255:0] held;
        logic [8:0]   held_cnt;
        logic [7:0]   kb;
        bit           saw_done;
        for (int i = 0; i < 256; i++) begin
            logic [7:0] v, s;
            v = tinv(8'(i));
            s = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]} ^ 8'h63;
            sb[i] = s;
        end
        for (int i = 0; i < 256; i++) isb[sb[i]] = 8'(i);
        exp_cand = '1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(cand_mask == '1, "R1 cand_mask", cand_mask, '1);
        chk(cand_count == 9'd256, "R1 cand_count", 256'(cand_count), 256'(256));
        chk(!done && !busy, "R1 done/busy", 256'({done, busy}), 256'(0));

        // R7 repeated single-bit faults at byte 5, same plaintext
        kb = key[5*8 +: 8];
        valid_pair(5, 8'h01, 2'd1, 8'h00, 32'h0, "onebit a");
        valid_pair(5, 8'h08, 2'd1, 8'h00, 32'h0, "onebit b");
        valid_pair(5, 8'h40, 2'd1, 8'h00, 32'h0, "onebit c");
        chk(cand_mask[kb], "R7 true key byte survives", 256'(cand_mask[kb]), 256'(1));

        // R3 zero differing bytes
        held = cand_mask; held_cnt = cand_count;
        run_pair(enc(st0), enc(st0), 2'd1, 8'h00, 32'h0);
        chk(cyc == 1, "R3 invalid latency", 256'(cyc), 256'(1));
        chk(!s_ok, "R3 zero diff pair_ok", 256'(s_ok), 256'(0));
        chk(s_pm == '0, "R3 pair_mask zero", s_pm, '0);
        chk(s_cm == held && s_cnt == held_cnt, "R3 mask held", s_cm, held);
        // R3 two differing bytes
        run_pair(enc(st0), enc(st0 ^ 128'h0000_0000_0000_0100_0000_0000_0000_0001), 2'd1, 8'h00, 32'h0);
        chk(!s_ok, "R3 two diff pair_ok", 256'(s_ok), 256'(0));
        chk(s_cm == held && s_cnt == held_cnt, "R3 two diff held", s_cm, held);

        // R12 clear, then R6 fixed model
        do_clear();
        chk(cand_mask == '1 && cand_count == 9'd256, "R12 clear", cand_mask, '1);
        valid_pair(12, 8'h5a, 2'd0, 8'h5a, 32'h0, "fixed");
        chk(cand_mask[key[12*8 +: 8]], "R6 key byte survives fixed", 256'(1'b0), 256'(1));

        // R8 set model
        do_clear();
        valid_pair(0, 8'h33, 2'd2, 8'h00, 32'h5a_80_01_33, "set");
        chk(cand_mask[key[7:0]], "R8 key byte survives set", 256'(1'b0), 256'(1));

        // R9 and R2: every byte position with the accept-all model
        do_clear();
        for (int p = 0; p < 16; p++) valid_pair(p, 8'(p + 1), 2'd3, 8'h00, 32'h0, "any");

        // R12 clear mid sweep: no done follows
        valid_pair(3, 8'h02, 2'd1, 8'h00, 32'h0, "pre-clear");
        @(negedge clk);
        ct_good = enc(st0); ct_bad = enc(st0 ^ (128'h04 << 24)); model = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (100) @(negedge clk);
        clear = 1'b1;
        @(negedge clk);
        clear = 1'b0;
        exp_cand = '1;
        chk(cand_mask == '1 && cand_count == 9'd256 && !busy, "R12 mid-sweep clear", cand_mask, '1);
        saw_done = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (done) saw_done = 1'b1;
        end
        chk(!saw_done, "R12 no done after clear", 256'(saw_done), 256'(0));

        // R13 start while busy is ignored
        begin
            logic [127:0] g1, b1;
            logic [255:0] em;
            g1 = enc(st0);
            b1 = enc(st0 ^ (128'h10 << 72));
            em = exp_mask(g1[72 +: 8], b1[72 +: 8], 2'd1, 8'h00, 32'h0);
            @(negedge clk);
            ct_good = g1; ct_bad = b1; model = 2'd1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            cyc = 1;
            repeat (50) begin @(negedge clk); cyc++; end
            ct_good = enc(st0); ct_bad = enc(st0 ^ (128'h80 << 16)); model = 2'd3; start = 1'b1;
            @(negedge clk);
            cyc++;
            start = 1'b0;
            while (!done && cyc < 400) begin @(negedge clk); cyc++; end
            chk(cyc == 257, "R13 original latency", 256'(cyc), 256'(257));
            chk(byte_pos == 4'd9, "R13 byte_pos kept", 256'(byte_pos), 256'(9));
            chk(pair_mask == em, "R13 pair_mask kept", pair_mask, em);
            @(negedge clk);
            chk(!busy, "R13 no second sweep", 256'(busy), 256'(0));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule